// File: doc/BRIEF.md
# Register-operand unary and widening-multiply unit

This unit executes the one-operand arithmetic group of a 32-bit integer core when the operand is a register. It takes the instruction's operand-format byte: bits 7:6 give the addressing mode, bits 5:3 select the operation, and bits 2:0 name the operand register. It reads the operand register and the accumulator (register 0) from the register file. It returns results on two write ports and keeps the sign, zero and overflow flags.

Three operations are supported. Bitwise inversion and two's-complement negation rewrite the operand register in place. The unsigned widening multiply multiplies the accumulator by the operand over several cycles. It then writes the low word of the 64-bit product to register 0 and the high word to register 2, both in the same cycle. A `busy`/`done` handshake holds off the next instruction until the result has been written. Negating the most negative value has no valid result. In that case the register keeps its value and the flags report the overflow.

Top module: `unary_mul_group`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `done`, `illegal`, `wr0En` and `wr1En` are 0 and all three flags are 0.
- R2: Operation code 2 (bits 5:3) with mode 3 (bits 7:6) writes the bitwise inverse of the operand to the register named by bits 2:0. `done` and the write appear in the cycle after the start is accepted.
- R3: Operation code 3 writes the two's complement of the operand back to the operand register, with the same one-cycle latency as R2.
- R4: Negating 0x80000000 writes no register and sets SF=1, ZF=0, OF=1.
- R5: After inversion, and after a negation that does not overflow, SF equals bit 31 of the result, ZF is 1 exactly when the result is zero, and OF is 0.
- R6: Operation code 4 forms the unsigned 64-bit product of register 0 and the operand. The low word is written to register 0 through port 0 and the high word to register 2 through port 1, in a single `done` cycle, 32/STEP_BITS+1 cycles after the start is accepted (5 cycles by default).
- R7: After a multiply, OF is 1 exactly when the high word is nonzero, and SF and ZF keep their previous values.
- R8: An operation code other than 2, 3 or 4, or a mode other than 3, gives `done` together with `illegal` one cycle after the start. No register is written and all flags are unchanged.
- R9: `busy` is high from the cycle after a start is accepted through the `done` cycle. A start that arrives while `busy` is high is ignored.
- R10: The flags change only at the clock edge that ends a `done` cycle, which is the same edge at which the register file takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the instruction in `modrm`; taken only while idle |
| modrm | input | 8 | Operand-format byte: mode, operation code, register |
| rdAddr | output | 3 | Read address of the operand register (bits 2:0 of `modrm`) |
| rdData | input | DATA_W | Contents of the register at `rdAddr` |
| accData | input | DATA_W | Contents of register 0 |
| busy | output | 1 | An instruction is in flight |
| done | output | 1 | Result cycle of the instruction |
| illegal | output | 1 | With `done`: the instruction was not recognized |
| wr0En | output | 1 | Write enable, port 0 |
| wr0Addr | output | 3 | Write address, port 0 |
| wr0Data | output | DATA_W | Write data, port 0 |
| wr1En | output | 1 | Write enable, port 1 (high word of a product) |
| wr1Addr | output | 3 | Write address, port 1 (always register 2) |
| wr1Data | output | DATA_W | Write data, port 1 |
| sfFlag | output | 1 | Sign flag |
| zfFlag | output | 1 | Zero flag |
| ofFlag | output | 1 | Overflow flag |

## Verification
The bench targets the following corner cases, and what a wrong design would show for each:
- Negating 0x80000000. A design that fails to special-case it would write 0x80000000 back and clear OF.
- Inverting all-ones. This must raise ZF.
- Negating zero. This must raise ZF and leave SF clear.
- Multiplies whose high word is zero or nonzero. These show an OF that ignores the high word, or SF/ZF that the multiply wrongly disturbs.
- A multiply whose operand is register 0. A design that read the operand after the product began to land would give a wrong square.
- A multiply whose operand is register 2. This shows the high-word write taking priority.
- A start issued during a multiply. A broken handshake would execute it and corrupt a register.
- Illegal codes and the memory addressing mode. A wrong design would write a register or move the flags.

// File: rtl/umg_pkg.sv
package umg_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] ACC_IDX = 3'd0;
  localparam logic [REG_AW-1:0] HI_IDX  = 3'd2;
  localparam logic [1:0] MODE_REG = 2'b11;
  localparam logic [2:0] CODE_INV = 3'd2;
  localparam logic [2:0] CODE_NEG = 3'd3;
  localparam logic [2:0] CODE_MUL = 3'd4;

  typedef enum logic [1:0] {K_INV, K_NEG, K_MUL, K_BAD} opKind_t;

  typedef struct packed {
    logic    load;
    logic    step;
    logic    commit;
    opKind_t kind;
  } ctrlStrobe_t;
endpackage

// File: rtl/umg_ctrl.sv
module umg_ctrl
  import umg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STEP_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  modrm,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        illegal
);
  localparam int STEPS = DATA_W / STEP_BITS;
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_FIN} state_t;

  state_t     state;
  opKind_t    kindReg;
  opKind_t    decKind;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    decKind = K_BAD;
    if (modrm[7:6] == MODE_REG) begin
      case (modrm[5:3])
        CODE_INV: decKind = K_INV;
        CODE_NEG: decKind = K_NEG;
        CODE_MUL: decKind = K_MUL;
        default:  decKind = K_BAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kindReg <= K_INV;
      stepCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          kindReg <= decKind;
          if (decKind == K_MUL) begin
            state   <= S_MUL;
            stepCnt <= CNT_W'(STEPS - 1);
          end else begin
            state <= S_FIN;
          end
        end
        S_MUL: begin
          if (stepCnt == '0) state <= S_FIN;
          else stepCnt <= stepCnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load   = (state == S_IDLE) && start;
    strobe.step   = (state == S_MUL);
    strobe.commit = (state == S_FIN);
    strobe.kind   = (state == S_IDLE) ? decKind : kindReg;
  end

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign illegal = (state == S_FIN) && (kindReg == K_BAD);
endmodule

// File: rtl/umg_datapath.sv
module umg_datapath
  import umg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STEP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [REG_AW-1:0] rmIn,
  input  logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] accData,
  output logic              wr0En,
  output logic [REG_AW-1:0] wr0Addr,
  output logic [DATA_W-1:0] wr0Data,
  output logic              wr1En,
  output logic [REG_AW-1:0] wr1Addr,
  output logic [DATA_W-1:0] wr1Data,
  output logic              sfFlag,
  output logic              zfFlag,
  output logic              ofFlag
);
  localparam int SUM_W = DATA_W + STEP_BITS;
  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic [REG_AW-1:0] rmReg;
  logic [DATA_W-1:0] unRes;
  logic              unOvf;
  logic [DATA_W-1:0] mcand;
  logic [DATA_W-1:0] hiReg;
  logic [DATA_W-1:0] loReg;
  logic [SUM_W-1:0]  partial;
  logic [SUM_W-1:0]  stepSum;
  logic              isUnary;
  logic              isMul;

  // One radix-2^STEP_BITS shift-add step: add chunk*mcand to the high word,
  // then shift the pair right by STEP_BITS.
  always_comb begin
    partial = {{STEP_BITS{1'b0}}, mcand} * {{DATA_W{1'b0}}, loReg[STEP_BITS-1:0]};
    stepSum = {{STEP_BITS{1'b0}}, hiReg} + partial;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmReg <= '0;
      unRes <= '0;
      unOvf <= 1'b0;
      mcand <= '0;
      hiReg <= '0;
      loReg <= '0;
    end else if (strobe.load) begin
      rmReg <= rmIn;
      mcand <= accData;
      hiReg <= '0;
      loReg <= rdData;
      unRes <= (strobe.kind == K_INV) ? ~rdData : (~rdData + 1'b1);
      unOvf <= (strobe.kind == K_NEG) && (rdData == MIN_VAL);
    end else if (strobe.step) begin
      hiReg <= stepSum[SUM_W-1:STEP_BITS];
      loReg <= {stepSum[STEP_BITS-1:0], loReg[DATA_W-1:STEP_BITS]};
    end
  end

  assign isUnary = strobe.commit && ((strobe.kind == K_INV) || (strobe.kind == K_NEG));
  assign isMul   = strobe.commit && (strobe.kind == K_MUL);

  assign wr0En   = (isUnary && !unOvf) || isMul;
  assign wr0Addr = isMul ? ACC_IDX : rmReg;
  assign wr0Data = isMul ? loReg : unRes;
  assign wr1En   = isMul;
  assign wr1Addr = HI_IDX;
  assign wr1Data = hiReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sfFlag <= 1'b0;
      zfFlag <= 1'b0;
      ofFlag <= 1'b0;
    end else if (isUnary) begin
      if (unOvf) begin
        sfFlag <= 1'b1;
        zfFlag <= 1'b0;
        ofFlag <= 1'b1;
      end else begin
        sfFlag <= unRes[DATA_W-1];
        zfFlag <= (unRes == '0);
        ofFlag <= 1'b0;
      end
    end else if (isMul) begin
      ofFlag <= (hiReg != '0);
    end
  end
endmodule

// File: rtl/unary_mul_group.sv
module unary_mul_group
  import umg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STEP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        modrm,
  output logic [2:0]        rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] accData,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              wr0En,
  output logic [2:0]        wr0Addr,
  output logic [DATA_W-1:0] wr0Data,
  output logic              wr1En,
  output logic [2:0]        wr1Addr,
  output logic [DATA_W-1:0] wr1Data,
  output logic              sfFlag,
  output logic              zfFlag,
  output logic              ofFlag
);
  ctrlStrobe_t strobe;

  assign rdAddr = modrm[2:0];

  umg_ctrl #(.DATA_W(DATA_W), .STEP_BITS(STEP_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .modrm(modrm),
    .strobe(strobe), .busy(busy), .done(done), .illegal(illegal)
  );

  umg_datapath #(.DATA_W(DATA_W), .STEP_BITS(STEP_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rmIn(modrm[2:0]),
    .rdData(rdData), .accData(accData),
    .wr0En(wr0En), .wr0Addr(wr0Addr), .wr0Data(wr0Data),
    .wr1En(wr1En), .wr1Addr(wr1Addr), .wr1Data(wr1Data),
    .sfFlag(sfFlag), .zfFlag(zfFlag), .ofFlag(ofFlag)
  );
endmodule

// File: rtl/unary_mul_group_chk.sv
module unary_mul_group_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              wr0En,
  input logic              wr1En,
  input logic [DATA_W-1:0] wr1Data,
  input logic              sfFlag,
  input logic              zfFlag,
  input logic              ofFlag
);
  // R9
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R9
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R2
  write_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0En || wr1En) |-> done);

  // R6
  pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr1En |-> wr0En);

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !wr0En && !wr1En));

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable({sfFlag, zfFlag, ofFlag}));

  // R4
  neg_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done && !illegal && !wr0En) |-> (sfFlag && !zfFlag && ofFlag));

  // R7
  mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr1En) |-> ((ofFlag == ($past(wr1Data) != '0)) && $stable({sfFlag, zfFlag})));
endmodule

bind unary_mul_group unary_mul_group_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/unary_mul_group_bench.sv
module unary_mul_group_bench;
  localparam int W = 32;
  localparam int MUL_LAT = 5;
  localparam int NVEC = 10;
  // {modrm, operand, accumulator}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'hD3, 32'h0F0F00FF, 32'h00000000},
    {8'hD0, 32'hFFFFFFFF, 32'h00000000},
    {8'hDB, 32'h00000001, 32'h00000000},
    {8'hE1, 32'h00000003, 32'h00000004},
    {8'hD9, 32'h00000000, 32'h00000000},
    {8'hE3, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {8'hDE, 32'h7FFFFFFF, 32'h00000000},
    {8'hE6, 32'h00010000, 32'h00010000},
    {8'hE0, 32'h12345678, 32'h00000000},
    {8'hE2, 32'h00000007, 32'h00000005}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] modrm = 8'h00;
  logic [2:0] rdAddr;
  logic [W-1:0] rdData, accData;
  logic busy, done, illegal, wr0En, wr1En, sfFlag, zfFlag, ofFlag;
  logic [2:0] wr0Addr, wr1Addr;
  logic [W-1:0] wr0Data, wr1Data;

  logic preEn = 1'b0;
  logic [2:0] preAddr = 3'd0;
  logic [W-1:0] preData = '0;
  logic [W-1:0] rf [8];

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      if (preEn) rf[preAddr] <= preData;
      if (wr0En) rf[wr0Addr] <= wr0Data;
      if (wr1En) rf[wr1Addr] <= wr1Data;
    end
  end

  assign rdData  = rf[rdAddr];
  assign accData = rf[0];

  unary_mul_group u_unary_mul_group (
    .clk(clk), .rst_n(rst_n), .start(start), .modrm(modrm),
    .rdAddr(rdAddr), .rdData(rdData), .accData(accData),
    .busy(busy), .done(done), .illegal(illegal),
    .wr0En(wr0En), .wr0Addr(wr0Addr), .wr0Data(wr0Data),
    .wr1En(wr1En), .wr1Addr(wr1Addr), .wr1Data(wr1Data),
    .sfFlag(sfFlag), .zfFlag(zfFlag), .ofFlag(ofFlag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic setReg(input logic [2:0] a, input logic [W-1:0] v);
    @(negedge clk);
    preEn = 1'b1; preAddr = a; preData = v;
    @(negedge clk);
    preEn = 1'b0;
  endtask

  // Issue one instruction, wait for done; returns latency in cycles.
  task automatic issue(input logic [7:0] m, output int lat);
    @(negedge clk);
    modrm = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runCase(input logic [7:0] m, input logic [W-1:0] op, input logic [W-1:0] acc, input string tag);
    logic [2:0] rm;
    logic [W-1:0] effAcc, effEdx, expRes;
    logic [63:0] prod;
    logic [2:0] oldFlags, expFlags;
    int lat;
    rm = m[2:0];
    setReg(3'd2, 32'h5A5A5A5A);
    setReg(3'd0, acc);
    setReg(rm, op);
    effAcc = (rm == 3'd0) ? op : acc;
    effEdx = (rm == 3'd2) ? op : 32'h5A5A5A5A;
    oldFlags = {sfFlag, zfFlag, ofFlag};
    issue(m, lat);
    // R10: flags not yet updated in the done cycle
    chk({sfFlag, zfFlag, ofFlag} == oldFlags, {"R10 ", tag}, 64'({sfFlag, zfFlag, ofFlag}), 64'(oldFlags));
    chk(!illegal, {"R8 ", tag, " legal"}, 64'(illegal), 64'd0);
    if (m[5:3] == 3'd4) begin
      prod = 64'(effAcc) * 64'(op);
      chk(lat == MUL_LAT, {"R6 ", tag, " latency"}, 64'(lat), 64'(MUL_LAT));
      @(negedge clk);
      chk(rf[0] == prod[31:0], {"R6 ", tag, " low"}, 64'(rf[0]), 64'(prod[31:0]));
      chk(rf[2] == prod[63:32], {"R6 ", tag, " high"}, 64'(rf[2]), 64'(prod[63:32]));
      expFlags = {oldFlags[2:1], prod[63:32] != 0};
      chk({sfFlag, zfFlag, ofFlag} == expFlags, {"R7 ", tag, " flags"}, 64'({sfFlag, zfFlag, ofFlag}), 64'(expFlags));
    end else begin
      expRes = (m[5:3] == 3'd2) ? ~op : (32'd0 - op);
      chk(lat == 1, {"R2 ", tag, " latency"}, 64'(lat), 64'd1);
      @(negedge clk);
      chk(rf[rm] == expRes, {(m[5:3] == 3'd2) ? "R2 " : "R3 ", tag, " result"}, 64'(rf[rm]), 64'(expRes));
      if (rm != 3'd2) chk(rf[2] == effEdx, {"R2 ", tag, " other reg"}, 64'(rf[2]), 64'(effEdx));
      expFlags = {expRes[31], expRes == 0, 1'b0};
      chk({sfFlag, zfFlag, ofFlag} == expFlags, {"R5 ", tag, " flags"}, 64'({sfFlag, zfFlag, ofFlag}), 64'(expFlags));
    end
  endtask

  task automatic runIllegal(input logic [7:0] m, input string tag);
    logic [2:0] oldFlags;
    int lat;
    setReg(m[2:0], 32'h0000C0DE);
    oldFlags = {sfFlag, zfFlag, ofFlag};
    issue(m, lat);
    chk(illegal && lat == 1, {"R8 ", tag, " illegal pulse"}, 64'({illegal, 8'(lat)}), 64'({1'b1, 8'd1}));
    chk(!wr0En && !wr1En, {"R8 ", tag, " no write"}, 64'({wr0En, wr1En}), 64'd0);
    @(negedge clk);
    chk(rf[m[2:0]] == 32'h0000C0DE, {"R8 ", tag, " reg kept"}, 64'(rf[m[2:0]]), 64'h0000C0DE);
    chk({sfFlag, zfFlag, ofFlag} == oldFlags, {"R8 ", tag, " flags kept"}, 64'({sfFlag, zfFlag, ofFlag}), 64'(oldFlags));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !illegal && !wr0En && !wr1En, "R1 ctrl in reset",
        64'({busy, done, illegal, wr0En, wr1En}), 64'd0);
    chk({sfFlag, zfFlag, ofFlag} == 3'b000, "R1 flags in reset", 64'({sfFlag, zfFlag, ofFlag}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr0En && !wr1En, "R1 after reset", 64'({busy, done, wr0En, wr1En}), 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      runCase(VEC[v][71:64], VEC[v][63:32], VEC[v][31:0], $sformatf("vec%0d", v));
    end

    // R4: negate of most negative value; set flags to 0/1/0 first via zero result
    runCase(8'hD9, 32'h0, 32'h0, "pre-ovf");
    setReg(3'd3, 32'h80000000);
    issue(8'hDB, lat);
    chk(!wr0En, "R4 no write", 64'(wr0En), 64'd0);
    @(negedge clk);
    chk(rf[3] == 32'h80000000, "R4 reg kept", 64'(rf[3]), 64'h80000000);
    chk({sfFlag, zfFlag, ofFlag} == 3'b101, "R4 flags", 64'({sfFlag, zfFlag, ofFlag}), 64'b101);

    // R7: multiply after overflow keeps SF/ZF=1/0, clears OF for zero high word
    runCase(8'hE1, 32'h2, 32'h3, "mul-after-ovf");

    // R8: illegal codes and non-register mode
    runIllegal(8'hC3, "code0");
    runIllegal(8'hFB, "code7");
    runIllegal(8'h13, "mode0");

    // R9: start during a multiply is ignored
    setReg(3'd1, 32'h00000005);
    setReg(3'd0, 32'h00000006);
    setReg(3'd3, 32'h00000007);
    @(negedge clk);
    modrm = 8'hE3; start = 1'b1;
    @(negedge clk);
    chk(busy, "R9 busy after accept", 64'(busy), 64'd1);
    modrm = 8'hD9;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == MUL_LAT, "R9 mul latency unchanged", 64'(lat), 64'(MUL_LAT));
    @(negedge clk);
    chk(!busy && !done, "R9 idle after done", 64'({busy, done}), 64'd0);
    chk(rf[1] == 32'h00000005, "R9 ignored start wrote nothing", 64'(rf[1]), 64'h5);
    chk(rf[0] == 32'd42, "R9 mul result", 64'(rf[0]), 64'd42);
    @(negedge clk);
    chk(!done, "R9 no late done", 64'(done), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule